// File: doc/BRIEF.md
# Hardware Breakpoint Match Unit

This block holds four breakpoint slots and watches a stream of memory and I/O accesses for hits. Each slot has a 32-bit linear address register. A shared control register gives each slot a length, an access type and two enable bits, one local and one global. The block compares every access event against every enabled slot on the untranslated linear address. It records all hitting slots in a sticky status register and raises a one-cycle debug request to the exception logic.

Software reads and writes the registers through a simple request port with a 3-bit register index. Indices 0 to 3 select the slot address registers, 6 selects status and 7 selects control. With the extension mode input clear, indices 4 and 5 are aliases of status and control. With it set, they raise an invalid-opcode fault. Every register access is gated by privilege: it is allowed at level 0, in real mode or in the management mode. Any other access raises a general-protection fault and changes nothing. Both faults are reported in the same cycle as the request, and the exception logic acts on them.

Top module: `bkpt_match_unit`

## Requirements
- R1: After reset the four address registers and the control register read as zero, the status register reads 0xFFFFFFF0, and dbg_req is low.
- R2: A slot's region is its address with bit 0 cleared for length code 1, bits 1:0 cleared for length codes 2 and 3, and used as-is for code 0. The region spans 1, 2 or 4 bytes for codes 0, 1 and 2/3. An event spans 1, 2 or 4 bytes from ev_addr for ev_size codes 0, 1 and 2/3. A slot hits when the two byte ranges overlap, with no wrap past the top of the address space.
- R3: The slot type field is 2 bits. Code 0 hits only on fetch (ev_kind 0). Code 1 hits only on data write (ev_kind 2). Code 2 hits on I/O read or write (ev_kind 3 or 4). Code 3 hits on data read or write (ev_kind 1 or 2).
- R4: Slot i hits only when its local enable (control bit 16+i) or its global enable (control bit 20+i) is set. Either bit alone is enough.
- R5: dbg_req is high for exactly the cycle after a valid event that hits at least one slot. All slots hit by that event set their status bits at the same edge.
- R6: Status bits 3:0 (one per slot) stay set until a status write, which replaces them with write data bits 3:0. A hit in the same cycle is ORed in. Status bits 31:4 always read as 1.
- R7: A register access with cpl nonzero and with neither real_mode nor mgmt_mode set raises fault_gp in that cycle, returns zero read data and changes no register. The fault_gp check takes precedence over fault_ud.
- R8: With ext_dbg set, a permitted access to index 4 or 5 raises fault_ud and changes nothing. With ext_dbg clear, index 4 accesses status and index 5 accesses control.
- R9: In the control register, bits [4i+1:4i] hold the length code of slot i and bits [4i+3:4i+2] hold its type code. Bits 31:24 are not stored and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpl | input | 2 | Current privilege level |
| real_mode | input | 1 | Real-address mode active |
| mgmt_mode | input | 1 | Management mode active |
| ext_dbg | input | 1 | Debug extensions mode: indices 4 and 5 fault |
| reg_req | input | 1 | Register access request |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_idx | input | 3 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the request cycle |
| fault_gp | output | 1 | General-protection fault for this access |
| fault_ud | output | 1 | Invalid-opcode fault for this access |
| ev_valid | input | 1 | Access event valid |
| ev_addr | input | 32 | Linear address of the access |
| ev_size | input | 2 | Access size code |
| ev_kind | input | 3 | Access kind: 0 fetch, 1 read, 2 write, 3 I/O read, 4 I/O write |
| dbg_req | output | 1 | Debug exception request pulse |

## Verification
The assertions assume that ev_kind only carries the five defined codes and that the inputs are known values after reset. They also assume that the privilege and mode inputs do not change within the cycle of a register request. The bench drives only defined kinds and size codes and sets privilege and mode inputs one cycle ahead of each access. It changes all inputs on the falling clock edge, so every request and event is a clean single-cycle pulse.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int LOC_LSB = 16;
  localparam int GLB_LSB = 20;
  localparam int CFG_W   = 4;

  localparam logic [2:0] RI_ALT_STAT = 3'd4;
  localparam logic [2:0] RI_ALT_CTRL = 3'd5;
  localparam logic [2:0] RI_STAT     = 3'd6;
  localparam logic [2:0] RI_CTRL     = 3'd7;

  typedef enum logic [1:0] {
    BT_EXEC  = 2'd0,
    BT_WRITE = 2'd1,
    BT_IO    = 2'd2,
    BT_DATA  = 2'd3
  } bp_type_e;

  typedef enum logic [2:0] {
    AK_FETCH = 3'd0,
    AK_READ  = 3'd1,
    AK_WRITE = 3'd2,
    AK_IO_RD = 3'd3,
    AK_IO_WR = 3'd4
  } acc_kind_e;

  // byte span minus one for a 2-bit length or size code
  function automatic logic [1:0] span_of(input logic [1:0] code);
    case (code)
      2'd0:    span_of = 2'd0;
      2'd1:    span_of = 2'd1;
      default: span_of = 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/bkpt_slot_cmp.sv
module bkpt_slot_cmp
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] bp_addr,
  input  logic [1:0]        len_code,
  input  logic [1:0]        type_code,
  input  logic              slot_en,
  input  logic              ev_valid,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [1:0]        ev_size,
  input  logic [2:0]        ev_kind,
  output logic              hit
);
  localparam int XW = ADDR_W + 1;

  logic [1:0]        bp_span;
  logic [1:0]        ev_span;
  logic [ADDR_W-1:0] bp_base;
  logic [XW-1:0]     b_lo, b_hi, a_lo, a_hi;
  logic              kind_ok;

  always_comb begin
    bp_span = span_of(len_code);
    ev_span = span_of(ev_size);
    bp_base = bp_addr & ~{{(ADDR_W-2){1'b0}}, bp_span};
    b_lo    = {1'b0, bp_base};
    b_hi    = b_lo + {{(XW-2){1'b0}}, bp_span};
    a_lo    = {1'b0, ev_addr};
    a_hi    = a_lo + {{(XW-2){1'b0}}, ev_span};
    case (bp_type_e'(type_code))
      BT_EXEC:  kind_ok = (ev_kind == AK_FETCH);
      BT_WRITE: kind_ok = (ev_kind == AK_WRITE);
      BT_IO:    kind_ok = (ev_kind == AK_IO_RD) || (ev_kind == AK_IO_WR);
      default:  kind_ok = (ev_kind == AK_READ) || (ev_kind == AK_WRITE);
    endcase
    hit = slot_en && ev_valid && kind_ok && (a_lo <= b_hi) && (b_lo <= a_hi);
  end
endmodule

// File: rtl/bkpt_regs.sv
module bkpt_regs
  import bkpt_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 priv_ok,
  input  logic                 ext_dbg,
  input  logic                 reg_req,
  input  logic                 reg_wr,
  input  logic [2:0]           reg_idx,
  input  logic [DATA_W-1:0]    reg_wdata,
  input  logic [NUM_SLOTS-1:0] hit_vec,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic                 fault_gp,
  output logic                 fault_ud,
  output logic [ADDR_W-1:0]    addr_q [NUM_SLOTS],
  output logic [DATA_W-1:0]    ctrl_q,
  output logic [NUM_SLOTS-1:0] sts_q
);
  localparam int RSV_W = DATA_W - NUM_SLOTS;

  function automatic logic [DATA_W-1:0] ctrl_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      m[CFG_W*s +: CFG_W] = '1;
      m[LOC_LSB + s]      = 1'b1;
      m[GLB_LSB + s]      = 1'b1;
    end
    return m;
  endfunction

  localparam logic [DATA_W-1:0] CTRL_MASK = ctrl_mask();

  logic                 alias_idx, go, sel_stat, sel_ctrl;
  logic                 addr_we [NUM_SLOTS];
  logic                 ctrl_we;
  logic [ADDR_W-1:0]    addr_d [NUM_SLOTS];
  logic [DATA_W-1:0]    ctrl_d;
  logic [NUM_SLOTS-1:0] sts_d;

  always_comb begin
    alias_idx = (reg_idx == RI_ALT_STAT) || (reg_idx == RI_ALT_CTRL);
    fault_gp  = reg_req && !priv_ok;
    fault_ud  = reg_req && priv_ok && ext_dbg && alias_idx;
    go        = reg_req && priv_ok && !(ext_dbg && alias_idx);
    sel_stat  = go && ((reg_idx == RI_STAT) || (reg_idx == RI_ALT_STAT));
    sel_ctrl  = go && ((reg_idx == RI_CTRL) || (reg_idx == RI_ALT_CTRL));
    ctrl_we   = sel_ctrl && reg_wr;
    reg_rdata = '0;
    if (go && !reg_wr) begin
      if (sel_stat) reg_rdata = {{RSV_W{1'b1}}, sts_q};
      if (sel_ctrl) reg_rdata = ctrl_q;
      for (int s = 0; s < NUM_SLOTS; s++)
        if (reg_idx == 3'(s)) reg_rdata = DATA_W'(addr_q[s]);
    end
  end

  always_comb begin
    for (int s = 0; s < NUM_SLOTS; s++) begin
      addr_we[s] = go && reg_wr && (reg_idx == 3'(s));
      addr_d[s]  = addr_we[s] ? ADDR_W'(reg_wdata) : addr_q[s];
    end
    ctrl_d = ctrl_we ? (reg_wdata & CTRL_MASK) : ctrl_q;
    sts_d  = ((sel_stat && reg_wr) ? reg_wdata[NUM_SLOTS-1:0] : sts_q) | hit_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SLOTS; s++) addr_q[s] <= '0;
      ctrl_q <= '0;
      sts_q  <= '0;
    end else begin
      for (int s = 0; s < NUM_SLOTS; s++)
        if (addr_we[s]) addr_q[s] <= addr_d[s];
      if (ctrl_we) ctrl_q <= ctrl_d;
      sts_q <= sts_d;
    end
  end
endmodule

// File: rtl/bkpt_match_unit.sv
module bkpt_match_unit
  import bkpt_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cpl,
  input  logic              real_mode,
  input  logic              mgmt_mode,
  input  logic              ext_dbg,
  input  logic              reg_req,
  input  logic              reg_wr,
  input  logic [2:0]        reg_idx,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              fault_gp,
  output logic              fault_ud,
  input  logic              ev_valid,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [1:0]        ev_size,
  input  logic [2:0]        ev_kind,
  output logic              dbg_req
);
  logic                 priv_ok;
  logic [ADDR_W-1:0]    addr_q [NUM_SLOTS];
  logic [DATA_W-1:0]    ctrl_q;
  logic [NUM_SLOTS-1:0] sts_q;
  logic [NUM_SLOTS-1:0] hit_vec;
  logic                 req_d, req_q;
  logic                 unused_ctrl;

  assign priv_ok     = real_mode || mgmt_mode || (cpl == 2'd0);
  assign unused_ctrl = ^ctrl_q;

  bkpt_regs #(
    .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .priv_ok(priv_ok), .ext_dbg(ext_dbg),
    .reg_req(reg_req), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .hit_vec(hit_vec), .reg_rdata(reg_rdata),
    .fault_gp(fault_gp), .fault_ud(fault_ud),
    .addr_q(addr_q), .ctrl_q(ctrl_q), .sts_q(sts_q)
  );

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic [CFG_W-1:0] cfg;
    assign cfg = ctrl_q[CFG_W*g +: CFG_W];
    bkpt_slot_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .bp_addr(addr_q[g]), .len_code(cfg[1:0]), .type_code(cfg[3:2]),
      .slot_en(ctrl_q[LOC_LSB + g] || ctrl_q[GLB_LSB + g]),
      .ev_valid(ev_valid), .ev_addr(ev_addr), .ev_size(ev_size),
      .ev_kind(ev_kind), .hit(hit_vec[g])
    );
  end

  assign req_d   = |hit_vec;
  assign dbg_req = req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end
endmodule

// File: rtl/bkpt_match_unit_chk.sv
module bkpt_match_unit_chk
  import bkpt_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int DATA_W    = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           cpl,
  input logic                 real_mode,
  input logic                 mgmt_mode,
  input logic                 ext_dbg,
  input logic                 reg_req,
  input logic                 reg_wr,
  input logic [2:0]           reg_idx,
  input logic [DATA_W-1:0]    reg_rdata,
  input logic                 fault_gp,
  input logic                 fault_ud,
  input logic                 ev_valid,
  input logic                 dbg_req,
  input logic [DATA_W-1:0]    ctrl_q,
  input logic [NUM_SLOTS-1:0] sts_q
);
  logic pl_ok, stat_wr, stat_rd;
  assign pl_ok   = real_mode || mgmt_mode || (cpl == 2'd0);
  assign stat_wr = reg_req && reg_wr && pl_ok &&
                   ((reg_idx == RI_STAT) || (reg_idx == RI_ALT_STAT && !ext_dbg));
  assign stat_rd = reg_req && !reg_wr && pl_ok && (reg_idx == RI_STAT);

  AST_REQ_AFTER_EVENT: assert property (@(posedge clk) disable iff (!rst_n) dbg_req |-> $past(ev_valid)); // R5
  AST_REQ_HAS_STATUS: assert property (@(posedge clk) disable iff (!rst_n) dbg_req |-> (sts_q != '0)); // R5
  AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n) dbg_req |-> $past((ctrl_q[LOC_LSB +: NUM_SLOTS] | ctrl_q[GLB_LSB +: NUM_SLOTS]) != '0)); // R4
  AST_GP_FREEZES_CTRL: assert property (@(posedge clk) disable iff (!rst_n) fault_gp |=> $stable(ctrl_q)); // R7
  AST_UD_NEEDS_EXT: assert property (@(posedge clk) disable iff (!rst_n) fault_ud |-> (ext_dbg && !fault_gp)); // R8
  AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n) !stat_wr |=> ((sts_q & $past(sts_q)) == $past(sts_q))); // R6
  AST_STS_RSVD_ONES: assert property (@(posedge clk) disable iff (!rst_n) stat_rd |-> (&reg_rdata[DATA_W-1:NUM_SLOTS])); // R6
endmodule

bind bkpt_match_unit bkpt_match_unit_chk #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpl(cpl), .real_mode(real_mode), .mgmt_mode(mgmt_mode),
  .ext_dbg(ext_dbg), .reg_req(reg_req), .reg_wr(reg_wr), .reg_idx(reg_idx),
  .reg_rdata(reg_rdata), .fault_gp(fault_gp), .fault_ud(fault_ud),
  .ev_valid(ev_valid), .dbg_req(dbg_req), .ctrl_q(ctrl_q), .sts_q(sts_q)
);

// File: tb/tb_bkpt_match_unit.sv
module tb_bkpt_match_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cpl = 2'd0;
  logic        real_mode = 1'b0, mgmt_mode = 1'b0, ext_dbg = 1'b0;
  logic        reg_req = 1'b0, reg_wr = 1'b0;
  logic [2:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        fault_gp, fault_ud;
  logic        ev_valid = 1'b0;
  logic [31:0] ev_addr = '0;
  logic [1:0]  ev_size = '0;
  logic [2:0]  ev_kind = '0;
  logic        dbg_req;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bkpt_match_unit dut (
    .clk(clk), .rst_n(rst_n), .cpl(cpl), .real_mode(real_mode), .mgmt_mode(mgmt_mode),
    .ext_dbg(ext_dbg), .reg_req(reg_req), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fault_gp(fault_gp), .fault_ud(fault_ud),
    .ev_valid(ev_valid), .ev_addr(ev_addr), .ev_size(ev_size), .ev_kind(ev_kind),
    .dbg_req(dbg_req)
  );

  typedef struct packed {
    logic [31:0] bp;
    logic [31:0] ctl;
    logic [31:0] ea;
    logic [1:0]  esz;
    logic [2:0]  ek;
    logic        hit;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{32'h1000, 32'h0001_0000, 32'h1000, 2'd0, 3'd0, 1'b1}, // R2 exact fetch
    '{32'h1000, 32'h0001_0000, 32'h1001, 2'd0, 3'd0, 1'b0}, // R2 next byte
    '{32'h1000, 32'h0001_0000, 32'h1000, 2'd0, 3'd1, 1'b0}, // R3 read vs exec
    '{32'h2000, 32'h0001_0007, 32'h2003, 2'd0, 3'd2, 1'b1}, // R2 last byte of 4
    '{32'h2000, 32'h0001_0007, 32'h2000, 2'd0, 3'd1, 1'b0}, // R3 read vs write-only
    '{32'h2002, 32'h0001_0007, 32'h2000, 2'd0, 3'd2, 1'b1}, // R2 mask bits 1:0
    '{32'h3001, 32'h0001_000D, 32'h3000, 2'd0, 3'd1, 1'b1}, // R2 mask bit 0
    '{32'h3001, 32'h0001_000D, 32'h2FFF, 2'd1, 3'd2, 1'b1}, // R2 straddling access
    '{32'h3004, 32'h0001_000C, 32'h3000, 2'd2, 3'd1, 1'b0}, // R2 just past access
    '{32'h3003, 32'h0001_000C, 32'h3000, 2'd2, 3'd1, 1'b1}, // R2 inside 4-byte access
    '{32'h4000, 32'h0001_0008, 32'h4000, 2'd0, 3'd3, 1'b1}, // R3 I/O read
    '{32'h4000, 32'h0001_0008, 32'h4000, 2'd0, 3'd4, 1'b1}, // R3 I/O write
    '{32'h4000, 32'h0001_0008, 32'h4000, 2'd0, 3'd1, 1'b0}, // R3 data read vs I/O
    '{32'h1000, 32'h0000_0000, 32'h1000, 2'd0, 3'd0, 1'b0}, // R4 no enable
    '{32'h1000, 32'h0010_0000, 32'h1000, 2'd0, 3'd0, 1'b1}, // R4 global only
    '{32'h3001, 32'h0001_000D, 32'h2FFE, 2'd0, 3'd1, 1'b0}  // R2 below region
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic acc(input bit wr, input logic [2:0] idx, input logic [31:0] wd,
                     output logic [31:0] rd, output logic gp, output logic ud);
    @(negedge clk);
    reg_req = 1'b1; reg_wr = wr; reg_idx = idx; reg_wdata = wd;
    #1;
    rd = reg_rdata; gp = fault_gp; ud = fault_ud;
    @(negedge clk);
    reg_req = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] wd);
    logic [31:0] rd; logic gp, ud;
    acc(1'b1, idx, wd, rd, gp, ud);
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] val);
    logic gp, ud;
    acc(1'b0, idx, '0, val, gp, ud);
  endtask

  task automatic fire(input logic [31:0] a, input logic [1:0] sz, input logic [2:0] k,
                      output logic req);
    @(negedge clk);
    ev_valid = 1'b1; ev_addr = a; ev_size = sz; ev_kind = k;
    @(negedge clk);
    ev_valid = 1'b0;
    req = dbg_req;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic gp, ud, req;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 dbg_req", {31'd0, dbg_req}, 32'd0);
    for (int i = 0; i < 4; i++) begin
      rd(3'(i), v); chk("R1 addr", v, 32'd0);
    end
    rd(3'd7, v); chk("R1 ctrl", v, 32'd0);
    rd(3'd6, v); chk("R1 status", v, 32'hFFFF_FFF0);

    // table of single-slot match cases (R2 R3 R4)
    for (int n = 0; n < NV; n++) begin
      wr(3'd0, VECS[n].bp);
      wr(3'd7, VECS[n].ctl);
      wr(3'd6, 32'd0);
      fire(VECS[n].ea, VECS[n].esz, VECS[n].ek, req);
      chk($sformatf("R2/R3/R4 row %0d dbg_req", n), {31'd0, req}, {31'd0, VECS[n].hit});
      rd(3'd6, v);
      chk($sformatf("R2/R3/R4 row %0d status", n), v, 32'hFFFF_FFF0 | {31'd0, VECS[n].hit});
    end

    // R5 simultaneous hits, single-cycle request
    wr(3'd0, 32'h5000);
    wr(3'd1, 32'h9000);
    wr(3'd2, 32'h5002);
    wr(3'd7, 32'h0007_0CCF);
    wr(3'd6, 32'd0);
    fire(32'h5002, 2'd0, 3'd1, req);
    chk("R5 multi dbg_req", {31'd0, req}, 32'd1);
    @(negedge clk);
    chk("R5 pulse drops", {31'd0, dbg_req}, 32'd0);
    rd(3'd6, v); chk("R5 both bits", v, 32'hFFFF_FFF5);

    // R6 sticky status and write replacement
    fire(32'h9000, 2'd0, 3'd2, req);
    rd(3'd6, v); chk("R6 accumulate", v, 32'hFFFF_FFF7);
    fire(32'h7000, 2'd0, 3'd1, req);
    chk("R6 miss no req", {31'd0, req}, 32'd0);
    rd(3'd6, v); chk("R6 sticky", v, 32'hFFFF_FFF7);
    wr(3'd6, 32'h0000_0002);
    rd(3'd6, v); chk("R6 write replaces", v, 32'hFFFF_FFF2);
    wr(3'd6, 32'd0);

    // R7 privilege
    @(negedge clk); cpl = 2'd3;
    acc(1'b1, 3'd7, 32'd0, v, gp, ud);
    chk("R7 gp on write", {30'd0, gp, ud}, 32'd2);
    acc(1'b0, 3'd0, 32'd0, v, gp, ud);
    chk("R7 gp read zero", v, 32'd0);
    acc(1'b1, 3'd6, 32'h0000_000F, v, gp, ud);
    chk("R7 gp on status", {31'd0, gp}, 32'd1);
    @(negedge clk); cpl = 2'd0;
    rd(3'd7, v); chk("R7 ctrl unchanged", v, 32'h0007_0CCF);
    rd(3'd6, v); chk("R7 status unchanged", v, 32'hFFFF_FFF0);
    @(negedge clk); cpl = 2'd3; real_mode = 1'b1;
    acc(1'b1, 3'd0, 32'h1234, v, gp, ud);
    chk("R7 real mode allowed", {31'd0, gp}, 32'd0);
    @(negedge clk); real_mode = 1'b0; mgmt_mode = 1'b1; cpl = 2'd2;
    acc(1'b0, 3'd0, 32'd0, v, gp, ud);
    chk("R7 mgmt mode read", v, 32'h1234);
    @(negedge clk); mgmt_mode = 1'b0; cpl = 2'd0;

    // R8 extension mode
    @(negedge clk); ext_dbg = 1'b1;
    acc(1'b1, 3'd5, 32'd0, v, gp, ud);
    chk("R8 ud on idx5", {30'd0, gp, ud}, 32'd1);
    acc(1'b0, 3'd4, 32'd0, v, gp, ud);
    chk("R8 ud on idx4", {30'd0, gp, ud}, 32'd1);
    acc(1'b0, 3'd6, 32'd0, v, gp, ud);
    chk("R8 idx6 normal", {ud, v[30:0]}, {1'b0, 31'h7FFF_FFF0});
    rd(3'd7, v); chk("R8 ctrl unchanged", v, 32'h0007_0CCF);
    @(negedge clk); cpl = 2'd3;
    acc(1'b0, 3'd4, 32'd0, v, gp, ud);
    chk("R7 gp precedence", {30'd0, gp, ud}, 32'd2);
    @(negedge clk); cpl = 2'd0; ext_dbg = 1'b0;
    wr(3'd5, 32'h0001_0000);
    rd(3'd7, v); chk("R8 idx5 aliases ctrl", v, 32'h0001_0000);
    acc(1'b0, 3'd4, 32'd0, v, gp, ud);
    chk("R8 idx4 aliases status", v, 32'hFFFF_FFF0);

    // R9 unused control bits
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd7, v); chk("R9 ctrl mask", v, 32'h00FF_FFFF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule